// File: doc/BRIEF.md
# Dynamic-Width External Bus Controller

This block runs multiplexed address/data cycles between a 16-bit core and external memory. The core presents one request at a time: an address, a read or write flag, a byte or word size, an instruction-fetch flag and the write data. The block first decides from the address, the fetch flag and the external-access pin whether the access belongs off-chip. It then sequences an address phase and a data phase on a shared address/data bus, driving the latch strobe, the read strobe, the two write-side strobes and the fetch indicator.

The bus width is chosen per cycle: when dynamic sizing is enabled, a width pin sampled at the end of the address phase selects a 16-bit or an 8-bit cycle; otherwise every cycle is 8 bits. A word access that lands on an 8-bit cycle is split into two byte cycles, low byte first, and the core sees a single completion pulse. A ready input stretches the data phase in steps of two clocks. Two configuration inputs choose how the strobes are read: the latch pin as a pulsed address latch or as an address-valid level, and the write pins as one write plus high-byte enable or as separate low-byte and high-byte writes.

One clock of this block stands for one oscillator period.

Top module: `xbus_ctrl`

## Requirements
- R1: `req_ext` is 0 when the address lies in 0x2000..0x5FFF and `ea_in` is 1, or when the address is at most 0x01FF and `req_ifetch` is 0; it is 1 for every other address/flag combination (code fetches from 0x0000..0x01FF are external).
- R2: A request with `req_ext` = 0 is ignored: no strobe moves, `bus_ad_oe` stays 0 and no `rsp_done` follows.
- R3: A request is accepted on the clock edge where `req_valid`, `req_ext` and `req_ready` are all 1; a cycle without waits is two address-phase clocks plus two data-phase clocks, and `rsp_done` rises on the fourth edge after acceptance and stays high for exactly one clock.
- R4: `bus_ready_in` is sampled only on the last data-phase clock; each sample at 0 adds two data-phase clocks. Its value at any other time has no effect on timing.
- R5: With `cfg_dyn_width` = 1, `bus_width_in` sampled on the last address-phase clock gives a 16-bit cycle when 1 and an 8-bit cycle when 0; with `cfg_dyn_width` = 0 every cycle is 8-bit.
- R6: A word request on an 8-bit cycle runs as two back-to-back byte cycles at the even address then the odd address, with one `rsp_done` after the second; the read result carries the first byte in bits 7:0 and the second in bits 15:8.
- R7: With `cfg_addr_valid` = 0, `bus_latch` is 1 exactly during address-phase clocks; with `cfg_addr_valid` = 1, `bus_latch` is 0 through every clock of the access (both halves of a split and all waits) and 1 when idle.
- R8: `bus_rd_n` is 0 exactly during data-phase clocks of reads, and never together with a write strobe.
- R9: With `cfg_split_wr` = 0, `bus_wr_n` is 0 during every data-phase clock of a write, and `bus_hi_n` is 0 during those clocks only on a 16-bit cycle that writes the upper lane (a word, or a byte at an odd address).
- R10: With `cfg_split_wr` = 1, during write data phases `bus_wr_n` is 0 when the even byte is written (a word on a 16-bit cycle, or an even address) and `bus_hi_n` is 0 when the odd byte is written (a word on a 16-bit cycle, or an odd address).
- R11: `bus_inst` is 1 through every clock of a read with `req_ifetch` = 1 and 0 for data reads and for all writes.
- R12: `bus_ad_oe` is 1 and `bus_ad_out` carries the address in the address phase; in a write data phase the bus carries the whole word on a 16-bit word cycle and the byte copied to both lanes otherwise (byte data taken from `req_wdata[7:0]`, or the high byte for the second half of a split); a byte read takes the upper lane on a 16-bit cycle at an odd address, the lower lane otherwise, and returns it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dyn_width | input | 1 | 1: width pin picks each cycle's width; 0: always 8-bit |
| cfg_addr_valid | input | 1 | 1: latch pin is an address-valid level; 0: pulsed latch |
| cfg_split_wr | input | 1 | 1: separate low/high write strobes; 0: write plus high-byte enable |
| ea_in | input | 1 | External-access select for the 0x2000..0x5FFF window |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_ext | output | 1 | Request address decodes as off-chip |
| req_addr | input | 16 | Request byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| bus_width_in | input | 1 | Width pin: 1 = 16-bit cycle |
| bus_ready_in | input | 1 | Ready pin: 0 inserts a wait |
| bus_latch | output | 1 | Address latch / address-valid strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write or low-byte write strobe, active low |
| bus_hi_n | output | 1 | High-byte enable or high-byte write strobe, active low |
| bus_inst | output | 1 | Instruction-fetch indicator |
| bus_ad_out | output | 16 | Address/data bus driven value |
| bus_ad_oe | output | 1 | Address/data bus drive enable |
| bus_ad_in | input | 16 | Address/data bus sampled value |

## Verification
The hardest situation to reach from the ports is a word access that splits into two narrow cycles while wait states stretch each half, because the width pin, the ready pin and the latch mode must all line up with phases the bench cannot see directly. The bench reaches it with a bus responder that watches the strobes: it records the address at each latch event, answers from a byte pattern computed from that address on the lane the chosen width implies, and holds ready low for a set number of last-data-clock samples by counting data-strobe clocks. Ready is also held low through every idle and address-phase clock, so any sampling outside the data phase would show up as extra latency.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus controller.
// Assumes: one phase encoding used by every submodule.
package xbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/xbus_decode.sv
// Off-chip address decode.
// Says whether a request must run on the external bus. Assumes the
// on-chip register space starts at address zero and the on-chip memory
// window is gated by the external-access pin.
module xbus_decode #(
    parameter int AW      = 16,
    parameter int REG_TOP = 'h01FF,
    parameter int WIN_LO  = 'h2000,
    parameter int WIN_HI  = 'h5FFF
) (
    input  logic [AW-1:0] addr,
    input  logic          ifetch,
    input  logic          ea,
    output logic          ext
);
    localparam logic [AW-1:0] L_REG_TOP = AW'(REG_TOP);
    localparam logic [AW-1:0] L_WIN_LO  = AW'(WIN_LO);
    localparam logic [AW-1:0] L_WIN_HI  = AW'(WIN_HI);

    logic in_regs;
    logic in_win;

    // Classify the address; code in register space always goes out.
    always_comb begin
        in_regs = (addr <= L_REG_TOP);
        in_win  = (addr >= L_WIN_LO) && (addr <= L_WIN_HI);
        ext     = !((in_win && ea) || (in_regs && !ifetch));
    end
endmodule

// File: rtl/xbus_seq.sv
// Bus cycle sequencer.
// Runs the address phase (2 clocks), the data phase (2 clocks plus 2 per
// wait), picks each cycle's width and splits narrow word accesses.
// Assumes configuration inputs are stable while a request is in flight
// and that one request is accepted only when idle.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_ext,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_ifetch,
    input  logic          cfg_dyn_width,
    input  logic          bus_width_in,
    input  logic          bus_ready_in,
    output phase_e        phase,
    output logic          half,
    output logic          bus16,
    output logic          wide,
    output logic [AW-1:0] cur_addr,
    output logic          op_write,
    output logic          op_ifetch,
    output logic          accept,
    output logic          cap,
    output logic          done
);
    logic sub;
    logic op_word;
    logic last_clk;
    logic need_split;

    // Handshake and end-of-cycle conditions.
    always_comb begin
        accept     = req_valid && req_ext && (phase == PH_IDLE);
        last_clk   = (phase == PH_DATA) && sub && bus_ready_in;
        need_split = op_word && !bus16 && !half;
        cap        = last_clk && !op_write;
        wide       = op_word && bus16 && !half;
    end

    // Phase state machine with split and wait handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sub       <= 1'b0;
            half      <= 1'b0;
            bus16     <= 1'b0;
            cur_addr  <= '0;
            op_write  <= 1'b0;
            op_word   <= 1'b0;
            op_ifetch <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase     <= PH_ADDR;
                        sub       <= 1'b0;
                        half      <= 1'b0;
                        cur_addr  <= req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
                        op_write  <= req_write;
                        op_word   <= req_word;
                        op_ifetch <= req_ifetch;
                    end
                end
                PH_ADDR: begin
                    if (!sub) begin
                        sub <= 1'b1;
                    end else begin
                        sub   <= 1'b0;
                        phase <= PH_DATA;
                        bus16 <= cfg_dyn_width && bus_width_in;
                    end
                end
                PH_DATA: begin
                    if (!sub) begin
                        sub <= 1'b1;
                    end else if (!bus_ready_in) begin
                        sub <= 1'b0;
                    end else if (need_split) begin
                        sub         <= 1'b0;
                        half        <= 1'b1;
                        cur_addr[0] <= 1'b1;
                        phase       <= PH_ADDR;
                    end else begin
                        sub   <= 1'b0;
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_IGNORE_ONCHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !req_ext) |=> (phase == PH_IDLE)); // R2
    AST_ADDR_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR && !sub) |=> (phase == PH_ADDR && sub)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_WAIT_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && sub && !bus_ready_in) |=> (phase == PH_DATA && !sub)); // R4
    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (last_clk && op_word && !bus16 && !half) |=> (phase == PH_ADDR && half && cur_addr[0])); // R6
endmodule

// File: rtl/xbus_lane.sv
// Address/data lane steering.
// Drives address then write data on the shared bus, and gathers read
// bytes into the result. Assumes the address and data buses have the
// same width and two byte lanes.
module xbus_lane
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          half,
    input  logic          bus16,
    input  logic          wide,
    input  logic [AW-1:0] cur_addr,
    input  logic          op_write,
    input  logic          accept,
    input  logic          cap,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_ad_in,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [DW-1:0] rdata
);
    localparam int BW    = DW / 2;
    localparam int LANES = 2;

    logic [DW-1:0] wdata_q;
    logic [BW-1:0] wbyte;
    logic [BW-1:0] rbyte;
    logic [BW-1:0] lane_in [LANES];

    // Split the sampled bus into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_in[g] = bus_ad_in[g*BW +: BW];
    end

    // Choose the write byte and the read lane for this cycle.
    always_comb begin
        wbyte = half ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];
        rbyte = (bus16 && cur_addr[0]) ? lane_in[1] : lane_in[0];
    end

    // Drive address in the address phase and data in write data phases.
    always_comb begin
        bus_ad_out = '0;
        bus_ad_oe  = 1'b0;
        if (phase == PH_ADDR) begin
            bus_ad_out = DW'(cur_addr);
            bus_ad_oe  = 1'b1;
        end else if (phase == PH_DATA && op_write) begin
            bus_ad_out = wide ? wdata_q : {wbyte, wbyte};
            bus_ad_oe  = 1'b1;
        end
    end

    // Hold write data from acceptance; assemble read results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                wdata_q <= req_wdata;
            end
            if (cap) begin
                if (wide) begin
                    rdata <= bus_ad_in;
                end else if (half) begin
                    rdata[DW-1:BW] <= rbyte;
                end else begin
                    rdata <= {{BW{1'b0}}, rbyte};
                end
            end
        end
    end

    AST_OE_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !op_write) |-> !bus_ad_oe); // R12
endmodule

// File: rtl/xbus_strobe.sv
// Bus strobe decoder.
// Produces latch, read, write, high-side and fetch pins from the current
// phase and the selected strobe meanings. Assumes outputs are decoded
// from registered state only.
module xbus_strobe
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   bus16,
    input  logic   wide,
    input  logic   addr_odd,
    input  logic   op_write,
    input  logic   op_ifetch,
    input  logic   cfg_addr_valid,
    input  logic   cfg_split_wr,
    output logic   bus_latch,
    output logic   bus_rd_n,
    output logic   bus_wr_n,
    output logic   bus_hi_n,
    output logic   bus_inst
);
    logic in_addr;
    logic in_data;
    logic active;
    logic lo_lane;
    logic hi_lane;
    logic wr_data;

    // Phase flags and lane ownership of the current byte(s).
    always_comb begin
        in_addr = (phase == PH_ADDR);
        in_data = (phase == PH_DATA);
        active  = in_addr || in_data;
        lo_lane = wide || !addr_odd;
        hi_lane = wide || addr_odd;
        wr_data = in_data && op_write;
    end

    // Map phases onto pins under the selected strobe meanings.
    always_comb begin
        bus_latch = cfg_addr_valid ? !active : in_addr;
        bus_rd_n  = !(in_data && !op_write);
        bus_inst  = active && op_ifetch && !op_write;
        if (cfg_split_wr) begin
            bus_wr_n = !(wr_data && lo_lane);
            bus_hi_n = !(wr_data && hi_lane);
        end else begin
            bus_wr_n = !wr_data;
            bus_hi_n = !(wr_data && bus16 && hi_lane);
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && (!bus_wr_n || !bus_hi_n))); // R8
    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_hi_n) |-> (phase == PH_DATA)); // R9
endmodule

// File: rtl/xbus_ctrl.sv
// External bus controller top.
// Decodes off-chip requests and runs multiplexed address/data cycles of
// per-cycle width. Assumes one outstanding request and configuration
// that changes only while idle.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int REG_TOP = 'h01FF,
    parameter int WIN_LO  = 'h2000,
    parameter int WIN_HI  = 'h5FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dyn_width,
    input  logic          cfg_addr_valid,
    input  logic          cfg_split_wr,
    input  logic          ea_in,
    input  logic          req_valid,
    output logic          req_ready,
    output logic          req_ext,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_ifetch,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    input  logic          bus_width_in,
    input  logic          bus_ready_in,
    output logic          bus_latch,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          bus_hi_n,
    output logic          bus_inst,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    input  logic [DW-1:0] bus_ad_in
);
    phase_e        phase;
    logic          half;
    logic          bus16;
    logic          wide;
    logic [AW-1:0] cur_addr;
    logic          op_write;
    logic          op_ifetch;
    logic          accept;
    logic          cap;

    // Idle indication toward the core.
    assign req_ready = (phase == PH_IDLE);

    xbus_decode #(.AW(AW), .REG_TOP(REG_TOP), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_decode (
        .addr   (req_addr),
        .ifetch (req_ifetch),
        .ea     (ea_in),
        .ext    (req_ext)
    );

    xbus_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ext       (req_ext),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_word      (req_word),
        .req_ifetch    (req_ifetch),
        .cfg_dyn_width (cfg_dyn_width),
        .bus_width_in  (bus_width_in),
        .bus_ready_in  (bus_ready_in),
        .phase         (phase),
        .half          (half),
        .bus16         (bus16),
        .wide          (wide),
        .cur_addr      (cur_addr),
        .op_write      (op_write),
        .op_ifetch     (op_ifetch),
        .accept        (accept),
        .cap           (cap),
        .done          (rsp_done)
    );

    xbus_lane #(.AW(AW), .DW(DW)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .half       (half),
        .bus16      (bus16),
        .wide       (wide),
        .cur_addr   (cur_addr),
        .op_write   (op_write),
        .accept     (accept),
        .cap        (cap),
        .req_wdata  (req_wdata),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .rdata      (rsp_rdata)
    );

    xbus_strobe u_strobe (
        .clk            (clk),
        .rst_n          (rst_n),
        .phase          (phase),
        .bus16          (bus16),
        .wide           (wide),
        .addr_odd       (cur_addr[0]),
        .op_write       (op_write),
        .op_ifetch      (op_ifetch),
        .cfg_addr_valid (cfg_addr_valid),
        .cfg_split_wr   (cfg_split_wr),
        .bus_latch      (bus_latch),
        .bus_rd_n       (bus_rd_n),
        .bus_wr_n       (bus_wr_n),
        .bus_hi_n       (bus_hi_n),
        .bus_inst       (bus_inst)
    );
endmodule

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dyn_width = 1'b1;
    logic        cfg_addr_valid = 1'b0;
    logic        cfg_split_wr = 1'b0;
    logic        ea_in = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ext;
    logic [15:0] req_addr = 16'h0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_ifetch = 1'b0;
    logic [15:0] req_wdata = 16'h0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        bus_width_in;
    logic        bus_ready_in;
    logic        bus_latch, bus_rd_n, bus_wr_n, bus_hi_n, bus_inst;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in;

    int total = 0;
    int bad = 0;

    // responder state
    logic        bw_drv = 1'b1;
    int          waits = 0;
    int          rcnt = 0;
    logic [15:0] la = 16'h0;
    logic        dp;
    logic        eff16;
    // monitor counters
    int n_l1, n_l0, n_rd, n_wr, n_hi, n_inst, n_oe;
    logic [15:0] wr_val, hi_val;

    always #2 clk = ~clk;

    xbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width),
        .cfg_addr_valid(cfg_addr_valid), .cfg_split_wr(cfg_split_wr), .ea_in(ea_in),
        .req_valid(req_valid), .req_ready(req_ready), .req_ext(req_ext),
        .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
        .req_ifetch(req_ifetch), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_width_in(bus_width_in), .bus_ready_in(bus_ready_in),
        .bus_latch(bus_latch), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_hi_n(bus_hi_n), .bus_inst(bus_inst), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    // Memory responder: lanes follow the width the bench drives.
    assign eff16        = cfg_dyn_width && bw_drv;
    assign bus_width_in = bw_drv;
    assign dp           = !bus_rd_n || !bus_wr_n || !bus_hi_n;
    assign bus_ready_in = dp && (rcnt > 2 * waits);   // low in idle/address phase on purpose (R4)
    assign bus_ad_in    = eff16 ? {pat(la | 16'h1), pat(la & 16'hFFFE)} : {8'hEE, pat(la)};

    always @(negedge clk) begin
        if (dp) rcnt = rcnt + 1; else rcnt = 0;
        if ((!cfg_addr_valid && bus_latch) ||
            (cfg_addr_valid && !bus_latch && !dp && bus_ad_oe)) la = bus_ad_out;
        if (bus_latch) n_l1 = n_l1 + 1; else n_l0 = n_l0 + 1;
        if (!bus_rd_n) n_rd = n_rd + 1;
        if (!bus_wr_n) begin n_wr = n_wr + 1; wr_val = bus_ad_out; end
        if (!bus_hi_n) begin n_hi = n_hi + 1; hi_val = bus_ad_out; end
        if (bus_inst) n_inst = n_inst + 1;
        if (bus_ad_oe) n_oe = n_oe + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        n_l1 = 0; n_l0 = 0; n_rd = 0; n_wr = 0; n_hi = 0; n_inst = 0; n_oe = 0;
        wr_val = 16'h0; hi_val = 16'h0;
    endtask

    // One request; returns clocks from acceptance edge to done edge.
    task automatic run(input logic [15:0] a, input logic wr, input logic wd,
                       input logic ifc, input logic [15:0] data, input int nw,
                       output int lat, output logic [15:0] rd);
        @(posedge clk); #1;
        waits = nw;
        req_addr = a; req_write = wr; req_word = wd; req_ifetch = ifc; req_wdata = data;
        req_valid = 1'b1;
        clr();
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!rsp_done && lat < 100);
        rd = rsp_rdata;
    endtask

    task automatic t_reset();
        chk("R3 reset ready", {31'b0, req_ready}, 1);
        chk("R3 reset done", {31'b0, rsp_done}, 0);
        chk("R7 reset latch", {31'b0, bus_latch}, 0);
        chk("R8 reset rd_n", {31'b0, bus_rd_n}, 1);
        chk("R9 reset wr/hi", {30'b0, bus_wr_n, bus_hi_n}, 2'b11);
        chk("R12 reset oe", {31'b0, bus_ad_oe}, 0);
    endtask

    task automatic t_decode();
        @(posedge clk); #1;
        req_ifetch = 1'b0; ea_in = 1'b1; req_addr = 16'h2100; #1;
        chk("R1 window ea=1", {31'b0, req_ext}, 0);
        ea_in = 1'b0; #1;
        chk("R1 window ea=0", {31'b0, req_ext}, 1);
        req_addr = 16'h5FFF; ea_in = 1'b1; #1;
        chk("R1 window top", {31'b0, req_ext}, 0);
        req_addr = 16'h6000; #1;
        chk("R1 above window", {31'b0, req_ext}, 1);
        req_addr = 16'h0100; #1;
        chk("R1 regs data", {31'b0, req_ext}, 0);
        req_ifetch = 1'b1; #1;
        chk("R1 regs code forced out", {31'b0, req_ext}, 1);
        req_ifetch = 1'b0; req_addr = 16'h0200; #1;
        chk("R1 above regs", {31'b0, req_ext}, 1);
    endtask

    task automatic t_ignore();
        @(posedge clk); #1;
        ea_in = 1'b1; req_addr = 16'h3000; req_write = 1'b0; req_ifetch = 1'b0;
        req_valid = 1'b1; clr();
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (rsp_done) n_oe = n_oe + 100;
        end
        req_valid = 1'b0;
        chk("R2 onchip no strobes", n_rd + n_wr + n_hi + n_l1, 0);
        chk("R2 onchip no drive/done", n_oe, 0);
        chk("R2 still ready", {31'b0, req_ready}, 1);
    endtask

    task automatic t_read16();
        int lat; logic [15:0] rd;
        cfg_dyn_width = 1'b1; bw_drv = 1'b1; cfg_addr_valid = 1'b0;
        run(16'h8000, 1'b0, 1'b1, 1'b1, 16'h0, 0, lat, rd);
        chk("R3 latency 16b word", lat, 4);
        chk("R12 word read", rd, {pat(16'h8001), pat(16'h8000)});
        chk("R7 latch pulse clocks", n_l1, 2);
        chk("R8 rd low clocks", n_rd, 2);
        chk("R11 inst clocks", n_inst, 4);
        chk("R12 oe only in addr phase", n_oe, 2);
        @(posedge clk); #1;
        chk("R3 done one clock", {31'b0, rsp_done}, 0);
    endtask

    task automatic t_wait();
        int lat; logic [15:0] rd;
        run(16'h8010, 1'b0, 1'b1, 1'b0, 16'h0, 3, lat, rd);
        chk("R4 three waits latency", lat, 10);
        chk("R4 rd stretched", n_rd, 8);
        chk("R11 data read no inst", n_inst, 0);
        chk("R4 data after waits", rd, {pat(16'h8011), pat(16'h8010)});
    endtask

    task automatic t_narrow();
        int lat; logic [15:0] rd;
        cfg_dyn_width = 1'b0; bw_drv = 1'b1;
        run(16'h6000, 1'b0, 1'b1, 1'b0, 16'h0, 0, lat, rd);
        chk("R5 fixed narrow split latency", lat, 8);
        chk("R6 split read assembled", rd, {pat(16'h6001), pat(16'h6000)});
        chk("R6 two latch pulses", n_l1, 4);
        cfg_dyn_width = 1'b1; bw_drv = 1'b0;
        run(16'h6021, 1'b0, 1'b1, 1'b0, 16'h0, 1, lat, rd);
        chk("R6 split with waits latency", lat, 12);
        chk("R6 odd word address aligned", rd, {pat(16'h6021), pat(16'h6020)});
        chk("R4 rd low per half", n_rd, 8);
    endtask

    task automatic t_bytes();
        int lat; logic [15:0] rd;
        cfg_dyn_width = 1'b1; bw_drv = 1'b1;
        run(16'h7003, 1'b0, 1'b0, 1'b0, 16'h0, 0, lat, rd);
        chk("R12 odd byte upper lane", rd, {8'h00, pat(16'h7003)});
        chk("R3 byte latency", lat, 4);
        bw_drv = 1'b0;
        run(16'h7005, 1'b0, 1'b0, 1'b0, 16'h0, 0, lat, rd);
        chk("R5 narrow odd byte lower lane", rd, {8'h00, pat(16'h7005)});
        chk("R5 narrow byte not split", lat, 4);
    endtask

    task automatic t_write_single();
        int lat; logic [15:0] rd;
        cfg_split_wr = 1'b0; bw_drv = 1'b1;
        run(16'h9000, 1'b1, 1'b1, 1'b1, 16'hBEEF, 0, lat, rd);
        chk("R9 word wr clocks", n_wr, 2);
        chk("R9 word hi clocks", n_hi, 2);
        chk("R12 word data", wr_val, 16'hBEEF);
        chk("R11 write no inst", n_inst, 0);
        run(16'h9002, 1'b1, 1'b0, 1'b0, 16'h0034, 0, lat, rd);
        chk("R9 even byte no hi", n_hi, 0);
        chk("R12 byte on both lanes", wr_val, 16'h3434);
        run(16'h9003, 1'b1, 1'b0, 1'b0, 16'h0056, 0, lat, rd);
        chk("R9 odd byte hi", n_hi, 2);
        bw_drv = 1'b0;
        run(16'h9005, 1'b1, 1'b0, 1'b0, 16'h0078, 0, lat, rd);
        chk("R9 narrow odd byte no hi", n_hi, 0);
        chk("R9 narrow write wr", n_wr, 2);
    endtask

    task automatic t_write_split();
        int lat; logic [15:0] rd;
        cfg_split_wr = 1'b1; bw_drv = 1'b1;
        run(16'hA000, 1'b1, 1'b1, 1'b0, 16'h1357, 0, lat, rd);
        chk("R10 word both strobes", {n_wr[15:0], n_hi[15:0]}, {16'd2, 16'd2});
        run(16'hA002, 1'b1, 1'b0, 1'b0, 16'h0011, 0, lat, rd);
        chk("R10 even byte low only", {n_wr[15:0], n_hi[15:0]}, {16'd2, 16'd0});
        run(16'hA003, 1'b1, 1'b0, 1'b0, 16'h0022, 0, lat, rd);
        chk("R10 odd byte high only", {n_wr[15:0], n_hi[15:0]}, {16'd0, 16'd2});
        bw_drv = 1'b0;
        run(16'hA100, 1'b1, 1'b1, 1'b0, 16'hA1B2, 0, lat, rd);
        chk("R6 split write latency", lat, 8);
        chk("R10 split low byte", wr_val, 16'hB2B2);
        chk("R10 split high byte", hi_val, 16'hA1A1);
        cfg_split_wr = 1'b0;
    endtask

    task automatic t_addr_valid();
        int lat; logic [15:0] rd;
        cfg_addr_valid = 1'b1; cfg_dyn_width = 1'b1; bw_drv = 1'b1;
        run(16'hC000, 1'b0, 1'b1, 1'b0, 16'h0, 2, lat, rd);
        chk("R7 valid low whole cycle", n_l0, 8);
        chk("R7 valid read data", rd, {pat(16'hC001), pat(16'hC000)});
        chk("R7 valid high at idle", {31'b0, bus_latch}, 1);
        bw_drv = 1'b0;
        run(16'hC040, 1'b0, 1'b1, 1'b0, 16'h0, 0, lat, rd);
        chk("R7 valid low across split", n_l0, 8);
        chk("R6 valid split data", rd, {pat(16'hC041), pat(16'hC040)});
        cfg_addr_valid = 1'b0; bw_drv = 1'b1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_decode();
        t_ignore();
        t_read16();
        t_wait();
        t_narrow();
        t_bytes();
        t_write_single();
        t_write_split();
        t_addr_valid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule